// File: doc/BRIEF.md
# Per-Destination Class-of-Service Request Scheduler

This block lives on a line card in front of a crossbar fabric. It keeps the occupancy state of a virtual output queue matrix: one queue per pair of internal destination and service class, sixteen of each by default. Cells themselves are stored elsewhere. The scheduler only counts them. It is told about each arriving cell through an enqueue strobe that carries the destination and class. Whenever it has no request outstanding, it chooses one non-empty queue and offers it to the fabric arbiter as a request (destination, class).

The arbiter answers with a grant or a refusal. A grant that names the outstanding request produces a dequeue strobe in the following cycle, and the counter of that queue drops by one. A refusal withdraws the request, and on the next choice the refused destination is passed over. Traffic for other outputs therefore keeps moving while one output is contended. A grant that does not match the outstanding request does nothing to the queues and raises a one-cycle error flag.

Class choice is strict priority, and a lower class number means a more urgent, real-time class. Within the chosen class, destinations are served in rotation. Two configuration inputs shape the choice. The first tells the scheduler whether the fabric gives each output one line or two, and the rotation changes to match. The second selects a reduced mode with three classes: constant rate, variable rate and multicast.

Top module: `cos_req_sched`

## Requirements
- R1: While reset is held, and in the cycles after it is released until the first enqueue, req_valid, deq_valid and gnt_err are 0 and every queue is empty.
- R2: Each queue counter saturates at 2^CNT_W-1 (15 by default). An enqueue to a full queue is dropped, so a queue hands out exactly min(enqueues, 15) dequeues. An enqueue and a dequeue of the same queue at the same edge leave its count unchanged.
- R3: A new request always takes the lowest-numbered class that holds an eligible non-empty queue. Class 0 is the most urgent. The destination's place in the rotation does not matter.
- R4: Among eligible destinations at the chosen class, the request goes to the first one at or after a rotation pointer that starts at 0 after reset. In one-line (cfg_asym=0) mode, a grant moves the pointer to one past the granted destination, wrapping from N_DEST-1 to 0. An outstanding request holds its destination and class until a response arrives.
- R5: A refusal (rej_valid with a request outstanding and no grant) drops req_valid at the next edge. The next choice skips the refused destination, even when that destination holds a more urgent class. Only that one choice skips it.
- R6: With cfg_legacy=1, only classes 0 (constant rate), 1 (variable rate) and 2 (multicast) are used. Enqueues to class 3 or above are dropped without changing any count, and such classes are never requested.
- R7: In two-line (cfg_asym=1) mode, grants alternate in their effect on the pointer. The first grant leaves the pointer on the granted destination. The next grant moves it to one past that grant's destination. A refusal restores the first-grant behaviour.
- R8: A gnt_valid with no request outstanding, or with a destination or class that differs from the request, sets gnt_err for exactly the next cycle. Such a grant causes no dequeue and leaves the request unchanged.
- R9: A matching grant makes deq_valid high for exactly the next cycle, with deq_dest and deq_class equal to the granted request. req_valid is 0 in that cycle, and the next request appears no earlier than the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cell slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| cfg_asym | input | 1 | 1: fabric with two output lines per destination; 0: one line |
| cfg_legacy | input | 1 | 1: three-class mode (classes 0..2 only) |
| enq_valid | input | 1 | A cell was stored for queue (enq_dest, enq_class) |
| enq_dest | input | DEST_W (4) | Destination of the stored cell |
| enq_class | input | CLS_W (4) | Class of the stored cell |
| gnt_valid | input | 1 | Arbiter grant for (gnt_dest, gnt_class) |
| gnt_dest | input | DEST_W (4) | Destination being granted |
| gnt_class | input | CLS_W (4) | Class being granted |
| rej_valid | input | 1 | Arbiter refusal of the outstanding request |
| req_valid | output | 1 | A request is outstanding |
| req_dest | output | DEST_W (4) | Destination of the request |
| req_class | output | CLS_W (4) | Class of the request |
| deq_valid | output | 1 | Dequeue one cell from (deq_dest, deq_class) |
| deq_dest | output | DEST_W (4) | Destination to dequeue |
| deq_class | output | CLS_W (4) | Class to dequeue |
| gnt_err | output | 1 | The previous cycle carried a grant that matched no request |

## Verification
The 256 counters, the rotation pointer, the pair flag and the skip register are all hidden. Each of them shows up at the ports only through the choice of the next request. A counter that is off by one, or that wrapped instead of saturating, shows up as a missing or extra dequeue when the queue is drained. That becomes visible within two cycles of the grant that should have been the last one.

A pointer or pair-flag error changes the destination of the very next request after a grant. A skip error shows up two cycles after a refusal. The reference model in the bench predicts every output on every cycle, so any such divergence is reported in the first cycle it reaches a port.

// File: rtl/cos_sched_pkg.sv
package cos_sched_pkg;

  // number of classes used in three-class mode: constant rate, variable rate, multicast
  localparam int LEGACY_CLASSES = 3;

  typedef enum logic [1:0] {
    RSP_NONE   = 2'd0,
    RSP_GRANT  = 2'd1,
    RSP_REFUSE = 2'd2,
    RSP_STRAY  = 2'd3
  } rsp_e;

endpackage

// File: rtl/cos_occ_array.sv
module cos_occ_array #(
  parameter int N_DEST  = 16,
  parameter int N_CLASS = 16,
  parameter int CNT_W   = 4,
  localparam int DEST_W = $clog2(N_DEST),
  localparam int CLS_W  = $clog2(N_CLASS)
) (
  input  logic                            clk,
  input  logic                            arst_n,
  input  logic                            inc_en,
  input  logic [DEST_W-1:0]               inc_dest,
  input  logic [CLS_W-1:0]                inc_class,
  input  logic                            dec_en,
  input  logic [DEST_W-1:0]               dec_dest,
  input  logic [CLS_W-1:0]                dec_class,
  output logic [N_CLASS-1:0][N_DEST-1:0]  nonempty
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  for (genvar gc = 0; gc < N_CLASS; gc++) begin : g_cls
    for (genvar gd = 0; gd < N_DEST; gd++) begin : g_dst
      logic [CNT_W-1:0] cnt_q, cnt_d;
      logic             hit_inc, hit_dec;

      assign hit_inc = inc_en && (inc_dest == DEST_W'(gd)) && (inc_class == CLS_W'(gc));
      assign hit_dec = dec_en && (dec_dest == DEST_W'(gd)) && (dec_class == CLS_W'(gc));

      always_comb begin
        cnt_d = cnt_q;
        if (hit_inc && !hit_dec && (cnt_q != CNT_MAX)) cnt_d = cnt_q + 1'b1;
        else if (hit_dec && !hit_inc)                  cnt_d = cnt_q - 1'b1;
      end

      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)                 cnt_q <= '0;
        else if (hit_inc || hit_dec) cnt_q <= cnt_d;
      end

      assign nonempty[gc][gd] = |cnt_q;
    end
  end

endmodule

// File: rtl/cos_pick.sv
module cos_pick #(
  parameter int N_DEST  = 16,
  parameter int N_CLASS = 16,
  localparam int DEST_W = $clog2(N_DEST),
  localparam int CLS_W  = $clog2(N_CLASS)
) (
  input  logic [N_CLASS-1:0][N_DEST-1:0] nonempty,
  input  logic [N_CLASS-1:0]             class_en,
  input  logic                           skip_v,
  input  logic [DEST_W-1:0]              skip_d,
  input  logic [DEST_W-1:0]              ptr,
  output logic                           found,
  output logic [DEST_W-1:0]              pick_d,
  output logic [CLS_W-1:0]               pick_c
);

  logic [N_CLASS-1:0][N_DEST-1:0] elig;
  logic [N_DEST-1:0]              row;

  always_comb begin
    for (int c = 0; c < N_CLASS; c++) begin
      for (int d = 0; d < N_DEST; d++) begin
        elig[c][d] = nonempty[c][d] && class_en[c] && !(skip_v && (skip_d == DEST_W'(d)));
      end
    end
  end

  // strict priority: scanning downward leaves the lowest eligible class
  always_comb begin
    found  = 1'b0;
    pick_c = '0;
    for (int c = N_CLASS - 1; c >= 0; c--) begin
      if (|elig[c]) begin
        found  = 1'b1;
        pick_c = CLS_W'(c);
      end
    end
  end

  assign row = elig[pick_c];

  // rotation: scanning downward leaves the smallest offset from the pointer
  always_comb begin
    int s;
    pick_d = '0;
    for (int k = N_DEST - 1; k >= 0; k--) begin
      s = int'(ptr) + k;
      if (s >= N_DEST) s = s - N_DEST;
      if (row[s]) pick_d = DEST_W'(s);
    end
  end

endmodule

// File: rtl/cos_req_sched.sv
module cos_req_sched
  import cos_sched_pkg::*;
#(
  parameter int N_DEST  = 16,
  parameter int N_CLASS = 16,
  parameter int CNT_W   = 4,
  localparam int DEST_W = $clog2(N_DEST),
  localparam int CLS_W  = $clog2(N_CLASS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_asym,
  input  logic              cfg_legacy,
  input  logic              enq_valid,
  input  logic [DEST_W-1:0] enq_dest,
  input  logic [CLS_W-1:0]  enq_class,
  input  logic              gnt_valid,
  input  logic [DEST_W-1:0] gnt_dest,
  input  logic [CLS_W-1:0]  gnt_class,
  input  logic              rej_valid,
  output logic              req_valid,
  output logic [DEST_W-1:0] req_dest,
  output logic [CLS_W-1:0]  req_class,
  output logic              deq_valid,
  output logic [DEST_W-1:0] deq_dest,
  output logic [CLS_W-1:0]  deq_class,
  output logic              gnt_err
);

  // reset: asserted asynchronously, released on the clock
  logic rs_meta_q, rs_sync_q, arst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_sync_q <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_sync_q <= rs_meta_q;
    end
  end
  assign arst_n = rs_sync_q;

  logic [N_CLASS-1:0]             class_en;
  logic [N_CLASS-1:0][N_DEST-1:0] nonempty;
  logic                           found;
  logic [DEST_W-1:0]              pick_d;
  logic [CLS_W-1:0]               pick_c;
  logic                           enq_ok;
  rsp_e                           rsp;

  logic              req_q, req_n;
  logic [DEST_W-1:0] rdst_q, rdst_n;
  logic [CLS_W-1:0]  rcls_q, rcls_n;
  logic              deq_q, deq_n;
  logic [DEST_W-1:0] ddst_q;
  logic [CLS_W-1:0]  dcls_q;
  logic              err_q, err_n;
  logic [DEST_W-1:0] ptr_q, ptr_n;
  logic              pair_q, pair_n;
  logic              skv_q, skv_n;
  logic [DEST_W-1:0] skd_q, skd_n;
  logic [DEST_W-1:0] next_after;

  always_comb begin
    for (int c = 0; c < N_CLASS; c++) begin
      class_en[c] = !cfg_legacy || (c < LEGACY_CLASSES);
    end
  end

  assign enq_ok = enq_valid && class_en[enq_class];

  cos_occ_array #(.N_DEST(N_DEST), .N_CLASS(N_CLASS), .CNT_W(CNT_W)) u_occ (
    .clk      (clk),
    .arst_n   (arst_n),
    .inc_en   (enq_ok),
    .inc_dest (enq_dest),
    .inc_class(enq_class),
    .dec_en   (deq_n),
    .dec_dest (rdst_q),
    .dec_class(rcls_q),
    .nonempty (nonempty)
  );

  cos_pick #(.N_DEST(N_DEST), .N_CLASS(N_CLASS)) u_pick (
    .nonempty(nonempty),
    .class_en(class_en),
    .skip_v  (skv_q),
    .skip_d  (skd_q),
    .ptr     (ptr_q),
    .found   (found),
    .pick_d  (pick_d),
    .pick_c  (pick_c)
  );

  always_comb begin
    if (gnt_valid && req_q && (gnt_dest == rdst_q) && (gnt_class == rcls_q)) rsp = RSP_GRANT;
    else if (gnt_valid)                                                     rsp = RSP_STRAY;
    else if (rej_valid && req_q)                                            rsp = RSP_REFUSE;
    else                                                                    rsp = RSP_NONE;
  end

  assign next_after = (rdst_q == DEST_W'(N_DEST - 1)) ? '0 : rdst_q + 1'b1;

  always_comb begin
    req_n  = req_q;
    rdst_n = rdst_q;
    rcls_n = rcls_q;
    ptr_n  = ptr_q;
    pair_n = pair_q;
    skv_n  = skv_q;
    skd_n  = skd_q;
    deq_n  = (rsp == RSP_GRANT);
    err_n  = (rsp == RSP_STRAY);
    if (req_q) begin
      case (rsp)
        RSP_GRANT: begin
          req_n = 1'b0;
          if (cfg_asym && !pair_q) begin
            ptr_n  = rdst_q;
            pair_n = 1'b1;
          end else begin
            ptr_n  = next_after;
            pair_n = 1'b0;
          end
        end
        RSP_REFUSE: begin
          req_n  = 1'b0;
          skv_n  = 1'b1;
          skd_n  = rdst_q;
          pair_n = 1'b0;
        end
        default: ;
      endcase
    end else begin
      skv_n = 1'b0;
      if (found) begin
        req_n  = 1'b1;
        rdst_n = pick_d;
        rcls_n = pick_c;
      end
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      req_q  <= 1'b0;
      rdst_q <= '0;
      rcls_q <= '0;
      deq_q  <= 1'b0;
      ddst_q <= '0;
      dcls_q <= '0;
      err_q  <= 1'b0;
      ptr_q  <= '0;
      pair_q <= 1'b0;
      skv_q  <= 1'b0;
      skd_q  <= '0;
    end else begin
      req_q  <= req_n;
      deq_q  <= deq_n;
      err_q  <= err_n;
      ptr_q  <= ptr_n;
      pair_q <= pair_n;
      skv_q  <= skv_n;
      skd_q  <= skd_n;
      if (!req_q) begin
        rdst_q <= rdst_n;
        rcls_q <= rcls_n;
      end
      if (deq_n) begin
        ddst_q <= rdst_q;
        dcls_q <= rcls_q;
      end
    end
  end

  assign req_valid = req_q;
  assign req_dest  = rdst_q;
  assign req_class = rcls_q;
  assign deq_valid = deq_q;
  assign deq_dest  = ddst_q;
  assign deq_class = dcls_q;
  assign gnt_err   = err_q;

endmodule

// File: rtl/cos_sched_chk.sv
module cos_sched_chk
  import cos_sched_pkg::*;
#(
  parameter int N_DEST  = 16,
  parameter int N_CLASS = 16,
  localparam int DEST_W = $clog2(N_DEST),
  localparam int CLS_W  = $clog2(N_CLASS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_legacy,
  input logic              gnt_valid,
  input logic [DEST_W-1:0] gnt_dest,
  input logic [CLS_W-1:0]  gnt_class,
  input logic              rej_valid,
  input logic              req_valid,
  input logic [DEST_W-1:0] req_dest,
  input logic [CLS_W-1:0]  req_class,
  input logic              deq_valid,
  input logic [DEST_W-1:0] deq_dest,
  input logic [CLS_W-1:0]  deq_class,
  input logic              gnt_err
);

  // R9: a dequeue follows only a grant that matched the outstanding request
  a_r9_deq_after_match: assert property (@(posedge clk) disable iff (!rst_n)
    deq_valid |-> $past(gnt_valid && req_valid && gnt_dest == req_dest && gnt_class == req_class));

  // R9: the dequeue carries the granted queue
  a_r9_deq_fields: assert property (@(posedge clk) disable iff (!rst_n)
    deq_valid |-> (deq_dest == $past(req_dest)) && (deq_class == $past(req_class)));

  // R9: no request while a dequeue is signalled
  a_r9_no_req_with_deq: assert property (@(posedge clk) disable iff (!rst_n)
    deq_valid |-> !req_valid);

  // R4: an unanswered request holds
  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !gnt_valid && !rej_valid) |=> req_valid && $stable(req_dest) && $stable(req_class));

  // R5: refusal withdraws the request
  a_r5_refuse_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rej_valid && !gnt_valid) |=> !req_valid);

  // R5: the first request after a refusal goes elsewhere
  a_r5_skip_refused: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_valid && rej_valid && !gnt_valid, 2) && req_valid && !$past(req_valid))
      |-> (req_dest != $past(req_dest, 2)));

  // R6: three-class mode never requests a higher class
  a_r6_legacy_class: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !$past(req_valid) && $past(cfg_legacy)) |-> (req_class < CLS_W'(LEGACY_CLASSES)));

  // R8: the error flag follows a grant and never comes with a dequeue
  a_r8_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_err |-> $past(gnt_valid) && !deq_valid);

endmodule

bind cos_req_sched cos_sched_chk #(.N_DEST(N_DEST), .N_CLASS(N_CLASS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_legacy(cfg_legacy),
  .gnt_valid (gnt_valid),
  .gnt_dest  (gnt_dest),
  .gnt_class (gnt_class),
  .rej_valid (rej_valid),
  .req_valid (req_valid),
  .req_dest  (req_dest),
  .req_class (req_class),
  .deq_valid (deq_valid),
  .deq_dest  (deq_dest),
  .deq_class (deq_class),
  .gnt_err   (gnt_err)
);

// File: tb/cos_req_sched_tb.sv
module cos_req_sched_tb;

  localparam int ND = 16;
  localparam int NC = 16;
  localparam int CW = 4;
  localparam int MAXC = (1 << CW) - 1;
  localparam int LEG = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_asym = 1'b0, cfg_legacy = 1'b0;
  logic       enq_valid = 1'b0;
  logic [3:0] enq_dest = '0, enq_class = '0;
  logic       gnt_valid = 1'b0;
  logic [3:0] gnt_dest = '0, gnt_class = '0;
  logic       rej_valid = 1'b0;
  logic       req_valid, deq_valid, gnt_err;
  logic [3:0] req_dest, req_class, deq_dest, deq_class;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cos_req_sched #(.N_DEST(ND), .N_CLASS(NC), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_asym(cfg_asym), .cfg_legacy(cfg_legacy),
    .enq_valid(enq_valid), .enq_dest(enq_dest), .enq_class(enq_class),
    .gnt_valid(gnt_valid), .gnt_dest(gnt_dest), .gnt_class(gnt_class),
    .rej_valid(rej_valid),
    .req_valid(req_valid), .req_dest(req_dest), .req_class(req_class),
    .deq_valid(deq_valid), .deq_dest(deq_dest), .deq_class(deq_class),
    .gnt_err(gnt_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int  m_cnt [ND][NC];
  bit  m_rv, m_dv, m_err, m_flag, m_skv, m_rs1, m_rs2;
  int  m_rd, m_rc, m_dd, m_dc, m_ptr, m_skd;

  always @(posedge clk) begin
    bit ok_g, bad, rf, f;
    int pc, pd, d;
    if (!rst_n || !m_rs2) begin
      foreach (m_cnt[i, j]) m_cnt[i][j] = 0;
      m_rv = 0; m_dv = 0; m_err = 0; m_flag = 0; m_skv = 0;
      m_rd = 0; m_rc = 0; m_dd = 0; m_dc = 0; m_ptr = 0; m_skd = 0;
    end else begin
      ok_g = gnt_valid && m_rv && int'(gnt_dest) == m_rd && int'(gnt_class) == m_rc;
      bad  = gnt_valid && !ok_g;
      rf   = rej_valid && m_rv && !gnt_valid;
      f = 0; pc = 0; pd = 0;
      for (int c = 0; c < NC; c++) begin
        if (!f && (!cfg_legacy || c < LEG)) begin
          for (int k = 0; k < ND; k++) begin
            d = (m_ptr + k) % ND;
            if (!f && m_cnt[d][c] > 0 && !(m_skv && d == m_skd)) begin
              f = 1; pc = c; pd = d;
            end
          end
        end
      end
      m_err = bad;
      m_dv  = ok_g;
      if (ok_g) begin
        m_dd = m_rd; m_dc = m_rc;
        m_cnt[m_rd][m_rc] = m_cnt[m_rd][m_rc] - 1;
      end
      if (enq_valid && (!cfg_legacy || int'(enq_class) < LEG))
        if (m_cnt[enq_dest][enq_class] < MAXC)
          m_cnt[enq_dest][enq_class] = m_cnt[enq_dest][enq_class] + 1;
      if (m_rv) begin
        if (ok_g) begin
          m_rv = 0;
          if (cfg_asym && !m_flag) begin m_ptr = m_rd; m_flag = 1; end
          else begin m_ptr = (m_rd + 1) % ND; m_flag = 0; end
        end else if (rf) begin
          m_rv = 0; m_skv = 1; m_skd = m_rd; m_flag = 0;
        end
      end else begin
        m_skv = 0;
        if (f) begin m_rv = 1; m_rd = pd; m_rc = pc; end
      end
    end
    m_rs2 = rst_n ? m_rs1 : 1'b0;
    m_rs1 = rst_n;
  end

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(req_valid == m_rv && (!m_rv || (int'(req_dest) == m_rd && int'(req_class) == m_rc)),
          "R4 request", int'(req_valid) * 1000 + int'(req_dest) * 16 + int'(req_class),
          int'(m_rv) * 1000 + m_rd * 16 + m_rc);
      chk(deq_valid == m_dv && (!m_dv || (int'(deq_dest) == m_dd && int'(deq_class) == m_dc)),
          "R9 dequeue", int'(deq_valid) * 1000 + int'(deq_dest) * 16 + int'(deq_class),
          int'(m_dv) * 1000 + m_dd * 16 + m_dc);
      chk(gnt_err == m_err, "R8 error flag", int'(gnt_err), int'(m_err));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(posedge clk); #2;
    enq_valid = 0; gnt_valid = 0; rej_valid = 0;
  endtask

  task automatic do_reset(input bit asym, input bit leg);
    step(); rst_n = 0; cfg_asym = asym; cfg_legacy = leg;
    repeat (3) step();
    rst_n = 1;
    repeat (3) step();
  endtask

  task automatic enq(input int d, input int c);
    step(); enq_valid = 1; enq_dest = 4'(d); enq_class = 4'(c);
  endtask

  task automatic wait_req();
    for (int i = 0; i < 10 && !req_valid; i++) step();
  endtask

  task automatic grant_now();
    step(); gnt_valid = 1; gnt_dest = req_dest; gnt_class = req_class;
  endtask

  int seq[8];
  int nseq;

  task automatic drain(input int cycles);
    nseq = 0;
    for (int i = 0; i < cycles; i++) begin
      step();
      if (deq_valid) begin
        if (nseq < 8) seq[nseq] = int'(deq_dest);
        nseq++;
      end
      if (req_valid) begin gnt_valid = 1; gnt_dest = req_dest; gnt_class = req_class; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(posedge clk); #2;
    chk(!req_valid && !deq_valid && !gnt_err, "R1 in reset", int'(req_valid), 0);
    do_reset(0, 0);
    chk(!req_valid && !deq_valid && !gnt_err, "R1 after release", int'(req_valid), 0);
    repeat (4) step();
    chk(!req_valid, "R1 empty queues", int'(req_valid), 0);

    // R3: priority beats rotation
    do_reset(0, 0);
    enq(5, 9); enq(5, 9); enq(7, 9); enq(8, 1);
    step(); wait_req();
    chk(int'(req_dest) == 5 && int'(req_class) == 9, "R4 first pick", int'(req_dest), 5);
    grant_now(); step(); wait_req();
    chk(int'(req_dest) == 8, "R3 urgent dest", int'(req_dest), 8);
    chk(int'(req_class) == 1, "R3 urgent class", int'(req_class), 1);

    // R5: refused destination skipped once
    do_reset(0, 0);
    enq(4, 0); enq(9, 2);
    step(); wait_req();
    chk(int'(req_dest) == 4, "R5 initial", int'(req_dest), 4);
    step(); rej_valid = 1;
    step();
    chk(!req_valid, "R5 withdrawn", int'(req_valid), 0);
    wait_req();
    chk(int'(req_dest) == 9 && int'(req_class) == 2, "R5 other dest", int'(req_dest), 9);
    grant_now(); step(); wait_req();
    chk(int'(req_dest) == 4 && int'(req_class) == 0, "R5 resume", int'(req_dest), 4);

    // R8 then R9: stray grant, then real grant
    do_reset(0, 0);
    enq(4, 0);
    step(); wait_req();
    step(); gnt_valid = 1; gnt_dest = 4'd5; gnt_class = 4'd0;
    step();
    chk(gnt_err, "R8 flag", int'(gnt_err), 1);
    chk(!deq_valid, "R8 no dequeue", int'(deq_valid), 0);
    chk(req_valid && int'(req_dest) == 4, "R8 request kept", int'(req_dest), 4);
    grant_now(); step();
    chk(deq_valid && int'(deq_dest) == 4 && int'(deq_class) == 0, "R9 dequeue", int'(deq_dest), 4);
    chk(!req_valid, "R9 gap", int'(req_valid), 0);

    // R2: saturation
    do_reset(0, 0);
    for (int i = 0; i < 20; i++) enq(5, 7);
    drain(80);
    chk(nseq == MAXC, "R2 saturated count", nseq, MAXC);

    // R6: three-class mode
    do_reset(0, 1);
    enq(1, 5);
    repeat (5) step();
    chk(!req_valid, "R6 high class ignored", int'(req_valid), 0);
    enq(1, 2);
    step(); wait_req();
    chk(req_valid && int'(req_class) == 2, "R6 multicast class", int'(req_class), 2);
    grant_now(); step();
    cfg_legacy = 0;
    repeat (6) step();
    chk(!req_valid, "R6 dropped enqueue", int'(req_valid), 0);

    // R7: two-line rotation
    do_reset(1, 0);
    for (int i = 0; i < 3; i++) enq(3, 0);
    for (int i = 0; i < 3; i++) enq(6, 0);
    drain(40);
    chk(nseq == 6, "R7 count", nseq, 6);
    chk(seq[0] == 3 && seq[1] == 3 && seq[2] == 6 && seq[3] == 6 && seq[4] == 3 && seq[5] == 6,
        "R7 order", seq[0] * 100000 + seq[1] * 10000 + seq[2] * 1000 + seq[3] * 100 + seq[4] * 10 + seq[5],
        3 * 100000 + 3 * 10000 + 6 * 1000 + 6 * 100 + 3 * 10 + 6);

    // R4: one-line rotation
    do_reset(0, 0);
    for (int i = 0; i < 3; i++) enq(3, 0);
    for (int i = 0; i < 3; i++) enq(6, 0);
    drain(40);
    chk(seq[0] == 3 && seq[1] == 6 && seq[2] == 3 && seq[3] == 6 && seq[4] == 3 && seq[5] == 6,
        "R4 order", seq[0] * 100000 + seq[1] * 10000 + seq[2] * 1000 + seq[3] * 100 + seq[4] * 10 + seq[5],
        3 * 100000 + 6 * 10000 + 3 * 1000 + 6 * 100 + 3 * 10 + 6);

    // mixed traffic under both fabrics and both class modes, model-compared
    for (int mode = 0; mode < 4; mode++) begin
      do_reset(mode[0], mode[1]);
      for (int i = 0; i < 3000; i++) begin
        int r;
        step();
        if ($urandom % 10 < 6) begin
          enq_valid = 1; enq_dest = 4'($urandom % ND); enq_class = 4'($urandom % NC);
        end
        r = int'($urandom % 8);
        if (req_valid) begin
          if (r < 4) begin gnt_valid = 1; gnt_dest = req_dest; gnt_class = req_class; end
          else if (r < 6) rej_valid = 1;
          else if (r == 6) begin gnt_valid = 1; gnt_dest = req_dest + 4'd1; gnt_class = req_class; end
        end else if (r == 6) begin
          gnt_valid = 1; gnt_dest = 4'($urandom % ND); gnt_class = 4'($urandom % NC);
        end else if (r == 7) rej_valid = 1;
      end
    end

    step(); step();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule